// File: doc/BRIEF.md
# GPIO Controller with Interrupt Pins

A register-mapped general-purpose I/O block for a configurable number of pads (22 by default). Software reaches it through a 32-bit word-wide register port with a valid/ready handshake. Each pad has its own output-enable and output-value bits, and a readable input level. Every pad input passes through a two-flop synchronizer before any other logic uses it.

A window of consecutive pads (pads 8 to 13 by default) can leave plain GPIO use and act as interrupt sources. Each pad in the window has a route bit in the function-select register. When routed, the pad drives its own dedicated interrupt line to an upstream interrupt controller. A per-line polarity bit decides whether a high or a low pad level is the active condition. The line is always presented active-high. The block holds no pending, mask or acknowledge state: it passes the level through, and the upstream controller latches, masks and clears it.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, pad_oe, pad_out and irq_out are all 0, and every register reads back 0.
- R2: A request (bus_valid high while bus_ready is low) is answered by bus_ready high for exactly one cycle, at the clock edge after the request is seen. bus_rdata is 0 whenever bus_ready is low.
- R3: Output enable is held at byte offset 0x29C and output value at 0x2A0. Bit p of each drives pad_oe[p] and pad_out[p], and the written value reads back.
- R4: The register at 0x2A4 returns the pad levels at bit p. A pad change becomes visible to a read that starts two clock edges after the change.
- R5: Function select is at 0x294. Bit 2*(8+n) is the route bit of interrupt line n, for n = 0..5, and it is writable and readable. Every other bit of this register reads 0 and ignores writes.
- R6: Polarity is at 0x290. Bit n selects line n: 1 means the line is active when the pad is high, 0 means it is active when the pad is low. Bits 6..31 read 0.
- R7: A routed line n drives irq_out[n] from pad 8+n: the pad level when polarity is 1, and its inverse when polarity is 0. A pad change appears on irq_out on the third clock edge after it.
- R8: irq_out[n] stays 0 while the route bit of line n is clear, whatever the pad level and polarity.
- R9: Bits 22..31 of the enable, value and input registers read 0. Writes to any other offset, including unaligned ones, change no state, and reads from such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle completion pulse |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| pad_in | input | 22 | Raw pad levels (asynchronous) |
| pad_oe | output | 22 | Per-pad output driver enable |
| pad_out | output | 22 | Per-pad driven value |
| irq_out | output | 6 | Active-high interrupt lines to upstream controller |

## Verification
A route or polarity bit in the wrong state has two visible effects. It shows up on irq_out three edges after any pad change as a stuck-low line or an inverted line, and a read of 0x294 or 0x290 exposes it at the next access. A broken synchronizer stage or a wrong latency shows up as irq_out or the input readback changing one edge too early or too late, so the bench samples the line at exact edge counts. Decode faults at the word level surface as non-zero reads of reserved bits or unmapped offsets, or as enable and value registers disturbed by a stray write. The bench reads these back right after the write.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Register byte offsets (software decodes these)
  localparam int unsigned OFS_POL  = 32'h290;
  localparam int unsigned OFS_SEL  = 32'h294;
  localparam int unsigned OFS_OE   = 32'h29C;
  localparam int unsigned OFS_OUT  = 32'h2A0;
  localparam int unsigned OFS_IN   = 32'h2A4;
  localparam int unsigned DATA_W   = 32;

  typedef enum logic [2:0] {
    REG_NONE, REG_POL, REG_SEL, REG_OE, REG_OUT, REG_IN
  } reg_sel_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
    end
  end

  assign dout = stage2_q;

  // second stage only ever takes the first stage's previous value
  AST_SYNC_CHAIN: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stage2_q == $past(stage1_q))); // R4
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int IRQ_BASE = 8,
  parameter int NUM_IRQ  = 6,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_ready,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] oe_q,
  output logic [NUM_PINS-1:0] out_q,
  output logic [NUM_IRQ-1:0]  route_q,
  output logic [NUM_IRQ-1:0]  pol_q
);
  localparam int SEL_TOP = 2 * (IRQ_BASE + NUM_IRQ - 1);

  logic        accept;
  reg_sel_e    hit;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] sel_view;
  logic [NUM_IRQ-1:0] route_wr;

  assign accept = bus_valid && !bus_ready;

  always_comb begin
    hit = REG_NONE;
    if      (bus_addr == ADDR_W'(OFS_POL)) hit = REG_POL;
    else if (bus_addr == ADDR_W'(OFS_SEL)) hit = REG_SEL;
    else if (bus_addr == ADDR_W'(OFS_OE))  hit = REG_OE;
    else if (bus_addr == ADDR_W'(OFS_OUT)) hit = REG_OUT;
    else if (bus_addr == ADDR_W'(OFS_IN))  hit = REG_IN;
  end

  // route bits live at the low bit of each pad's 2-bit field
  always_comb begin
    sel_view = '0;
    route_wr = '0;
    for (int n = 0; n < NUM_IRQ; n++) begin
      sel_view[2*(IRQ_BASE+n)] = route_q[n];
      route_wr[n]              = bus_wdata[2*(IRQ_BASE+n)];
    end
  end

  always_comb begin
    unique case (hit)
      REG_POL: rd_mux = DATA_W'(pol_q);
      REG_SEL: rd_mux = sel_view;
      REG_OE:  rd_mux = DATA_W'(oe_q);
      REG_OUT: rd_mux = DATA_W'(out_q);
      REG_IN:  rd_mux = DATA_W'(pin_sync);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
      oe_q      <= '0;
      out_q     <= '0;
      route_q   <= '0;
      pol_q     <= '0;
    end else begin
      bus_ready <= accept;
      bus_rdata <= '0;
      if (accept) begin
        if (bus_write) begin
          case (hit)
            REG_POL: pol_q   <= bus_wdata[NUM_IRQ-1:0];
            REG_SEL: route_q <= route_wr;
            REG_OE:  oe_q    <= bus_wdata[NUM_PINS-1:0];
            REG_OUT: out_q   <= bus_wdata[NUM_PINS-1:0];
            default: ;
          endcase
        end else begin
          bus_rdata <= rd_mux;
        end
      end
    end
  end

  initial begin
    assert (SEL_TOP < DATA_W);
    assert (NUM_PINS <= DATA_W);
    assert (IRQ_BASE + NUM_IRQ <= NUM_PINS);
  end

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    bus_ready |=> !bus_ready); // R2
  AST_READY_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> bus_ready); // R2
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bus_ready |-> (bus_rdata == '0)); // R2
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_ready && bus_write) |=>
      ($stable(oe_q) && $stable(out_q) && $stable(route_q) && $stable(pol_q))); // R9
endmodule

// File: rtl/gpio_irq_lines.sv
module gpio_irq_lines #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IRQ-1:0] pin_lvl,
  input  logic [NUM_IRQ-1:0] route,
  input  logic [NUM_IRQ-1:0] active_high,
  output logic [NUM_IRQ-1:0] irq_q
);
  for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
    logic asserted;
    assign asserted = active_high[n] ? pin_lvl[n] : !pin_lvl[n];

    always_ff @(posedge clk) begin
      if (rst) irq_q[n] <= 1'b0;
      else     irq_q[n] <= route[n] && asserted;
    end

    AST_UNROUTED_LOW: assert property (@(posedge clk) disable iff (rst)
      !route[n] |=> !irq_q[n]); // R8
    AST_ACTIVE_HIGH_PASS: assert property (@(posedge clk) disable iff (rst)
      (route[n] && active_high[n]) |=> (irq_q[n] == $past(pin_lvl[n]))); // R7
    AST_ACTIVE_LOW_INVERT: assert property (@(posedge clk) disable iff (rst)
      (route[n] && !active_high[n]) |=> (irq_q[n] == !$past(pin_lvl[n]))); // R7
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int IRQ_BASE = 8,
  parameter int NUM_IRQ  = 6,
  parameter int ADDR_W   = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                bus_ready,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_IRQ-1:0]  irq_out
);
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_IRQ-1:0]  route_q;
  logic [NUM_IRQ-1:0]  pol_q;

  gpio_irq_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (pad_in),
    .dout (pin_sync)
  );

  gpio_irq_regs #(
    .NUM_PINS (NUM_PINS),
    .IRQ_BASE (IRQ_BASE),
    .NUM_IRQ  (NUM_IRQ),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_ready (bus_ready),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .oe_q      (pad_oe),
    .out_q     (pad_out),
    .route_q   (route_q),
    .pol_q     (pol_q)
  );

  gpio_irq_lines #(.NUM_IRQ(NUM_IRQ)) u_lines (
    .clk         (clk),
    .rst         (rst),
    .pin_lvl     (pin_sync[IRQ_BASE +: NUM_IRQ]),
    .route       (route_q),
    .active_high (pol_q),
    .irq_q       (irq_out)
  );

  AST_RESET_OUTPUTS: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && irq_out == '0 && !bus_ready)); // R1
endmodule

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;
  localparam int NP = 22;
  localparam int NI = 6;
  localparam int BASE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] pad_out;
  logic [NI-1:0] irq_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gpio_irq_ctrl uut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
    .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq_out(irq_out)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sel_word(logic [NI-1:0] r);
    logic [31:0] w = '0;
    for (int n = 0; n < NI; n++) w[2*(BASE+n)] = r[n];
    return w;
  endfunction

  function automatic logic [NI-1:0] exp_irq(logic [NP-1:0] pads, logic [NI-1:0] r,
                                            logic [NI-1:0] p);
    return r & ~(pads[BASE +: NI] ^ p);
  endfunction

  // one access; returns the completion data; ends on a negedge with ready low
  task automatic access(input bit wr, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output bit rdy);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    rdy = bus_ready;
    rd  = bus_rdata;
    @(negedge clk);
    bus_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic [31:0] rd; bit rdy;
    access(1'b1, a, d, rd, rdy);
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bit rdy;
    access(1'b0, a, 32'h0, d, rdy);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [NI-1:0] r_m, p_m;
    logic [NP-1:0] oe_m, out_m;
    logic [31:0] seed_use;
    bit rdy;
    seed_use = $urandom(32'd1234);

    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    check("R1 pad_oe", 32'(pad_oe), 0);
    check("R1 pad_out", 32'(pad_out), 0);
    check("R1 irq_out", 32'(irq_out), 0);
    rd(12'h290, v); check("R1 pol", v, 0);
    rd(12'h294, v); check("R1 sel", v, 0);
    rd(12'h29C, v); check("R1 oe", v, 0);

    // R2 handshake: ready on the edge after request, then low; rdata 0 when idle
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'h29C;
    #1 check("R2 ready before edge", 32'(bus_ready), 0);
    @(posedge clk); #1 check("R2 ready after edge", 32'(bus_ready), 1);
    @(posedge clk); #1 check("R2 ready single pulse", 32'(bus_ready), 0);
    check("R2 rdata idle", bus_rdata, 0);
    @(negedge clk); bus_valid = 1'b0;
    @(posedge clk); @(negedge clk);

    // R3 directed
    wr(12'h29C, 32'hFFFF_FFFF);
    check("R3 pad_oe all", 32'(pad_oe), 32'h003F_FFFF);
    rd(12'h29C, v); check("R9 oe upper bits", v, 32'h003F_FFFF);
    wr(12'h2A0, 32'h0015_A5A5);
    check("R3 pad_out", 32'(pad_out), 32'h0015_A5A5);

    // R5 select register masking
    wr(12'h294, 32'hFFFF_FFFF);
    rd(12'h294, v); check("R5 sel mask", v, sel_word('1));
    wr(12'h294, 32'h0);
    // R6 polarity masking
    wr(12'h290, 32'hFFFF_FFFF);
    rd(12'h290, v); check("R6 pol mask", v, 32'h3F);

    // R9 unmapped / unaligned writes change nothing, reads give 0
    wr(12'h298, 32'hFFFF_FFFF);
    wr(12'h29E, 32'h0);
    wr(12'h000, 32'h0);
    rd(12'h298, v); check("R9 unmapped read", v, 0);
    rd(12'h2A1, v); check("R9 unaligned read", v, 0);
    check("R9 oe kept", 32'(pad_oe), 32'h003F_FFFF);
    check("R9 out kept", 32'(pad_out), 32'h0015_A5A5);
    rd(12'h290, v); check("R9 pol kept", v, 32'h3F);

    // R8 unrouted lines stay low, pads high, active-high
    pad_in = '1;
    repeat (4) @(negedge clk);
    check("R8 unrouted low", 32'(irq_out), 0);

    // R7 exact latency: route line 0 active-high, toggle pad 8
    wr(12'h294, sel_word(6'b000001));
    pad_in = '0;
    repeat (4) @(negedge clk);
    check("R7 line0 idle", 32'(irq_out), 0);
    pad_in[BASE] = 1'b1;          // change at a negedge
    @(negedge clk); check("R7 latency edge1", 32'(irq_out[0]), 0);
    @(negedge clk); check("R7 latency edge2", 32'(irq_out[0]), 0);
    @(negedge clk); check("R7 latency edge3", 32'(irq_out[0]), 1);

    // R4 input readback timing: read issued two edges after change sees it
    pad_in = 22'h2A_5A5A;
    @(negedge clk); @(negedge clk);
    rd(12'h2A4, v); check("R4 input read", v, 32'h002A_5A5A);

    // R7 active-low inversion on line 2
    wr(12'h290, 32'h0);
    wr(12'h294, sel_word(6'b000100));
    pad_in = '0;
    repeat (4) @(negedge clk);
    check("R7 active-low asserted", 32'(irq_out), 32'h4);
    pad_in[BASE+2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 active-low released", 32'(irq_out), 0);

    // randomized mix
    for (int it = 0; it < 60; it++) begin
      r_m   = NI'($urandom);
      p_m   = NI'($urandom);
      oe_m  = NP'($urandom);
      out_m = NP'($urandom);
      wr(12'h290, {$urandom} | 32'(p_m));
      wr(12'h290, {26'($urandom), p_m});
      wr(12'h294, sel_word(r_m) | ($urandom & ~sel_word('1)));
      wr(12'h29C, {10'($urandom), oe_m});
      wr(12'h2A0, {10'($urandom), out_m});
      pad_in = NP'($urandom);
      repeat (4) @(negedge clk);
      check("R7/R8 random irq", 32'(irq_out), 32'(exp_irq(pad_in, r_m, p_m)));
      check("R3 random oe", 32'(pad_oe), 32'(oe_m));
      check("R3 random out", 32'(pad_out), 32'(out_m));
      rd(12'h2A4, v); check("R4 random input", v, 32'(pad_in));
      rd(12'h294, v); check("R5 random sel", v, sel_word(r_m));
      rd(12'h290, v); check("R6 random pol", v, 32'(p_m));
      access(1'b1, 12'(12'h300 + 4 * ($urandom % 16)), $urandom, v, rdy);
      check("R9 random unmapped", 32'(pad_oe), 32'(oe_m));
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule